// File: doc/BRIEF.md
# Reply Packet Receiver with Wait-Time Extension Handling

This block sits on the host side of a byte-wide device link. It fetches a reply packet from the device's read FIFO one byte at a time, and only takes a byte when the device's status byte shows read data present (bit 7). It collects a four-byte header, checks the protocol version byte and then acts on the control byte. Data packets are read in full. Their six-byte inner header is dropped, and the rest is streamed out as payload.

The device may ask for more processing time. The receiver answers such a request itself: it writes a four-byte grant frame back through the device's write FIFO, and each written byte waits for status bit 0. It then pauses for a set number of cycles and listens for a fresh header. After a set number of grants, the next request gets an abort frame instead. When reception ends, the block raises a one-cycle completion pulse together with a result code and a payload length.

Top module: `reply_rx`

## Requirements
- R1: After reset, `busy`, `done`, `payValid`, `rdStrobe` and `wrStrobe` are low. A packet starts only on a `start` pulse while idle.
- R2: Header bytes are taken only in cycles where `devStat[7]` is high. When four header bytes have been read and byte 0 is not 0x01, reception ends with result 2 (protocol error), and no further byte is read.
- R3: Control byte 0x04 is a data packet, and header bytes 2 and 3 give its body length, high byte first. All body bytes are read. Body bytes 0..5 are dropped and the remaining bytes appear in order on `payByte` with `payValid`. The result is 0 and `length` equals the body length minus 6, or 0 when the body length is 6 or less.
- R4: Control byte 0x10, when fewer than MAX_GRANTS requests have been granted in this reception, makes the block write 0x01 0x10 0x00 0x00. Each write happens only in a cycle where `devStat[7]`... is ignored and `devStat[0]` is high. After the last write the block reads nothing for PAUSE_CYCLES cycles, then reads a new header. The first read comes exactly PAUSE_CYCLES+1 cycles after the last write when data is waiting.
- R5: Control byte 0x10, arriving after MAX_GRANTS grants, makes the block write 0x01 0x18 0x00 0x00 instead and clear the grant count. The following request is granted again.
- R6: The grant count is cleared at every `start`.
- R7: Control byte 0x18 ends reception with result 1 (abort acknowledged) and `length` 0.
- R8: Control byte 0x20 makes the block read one more byte. If that byte is 0x15 the result is 4 (negative acknowledgement, retransmit); otherwise it is 3 (device error).
- R9: A data packet whose body length is 0x6D00 and whose body byte 1 is 0x80 ends, once all its bytes are read, with result 5 (vendor-layer error). Body byte 1 equal to 0x80 with any other length gives result 0.
- R10: A read or write wait that sees its status bit low on MAX_POLLS consecutive cycles ends reception with result 6 (timeout). A bit that rises on the last allowed cycle is still accepted.
- R11: Any other control byte ends reception with result 7 (unknown packet).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to receive a reply |
| devStat | input | 8 | Device status byte; bit 7 = read data present, bit 0 = write FIFO free |
| rdByte | input | 8 | Byte at the head of the device read FIFO |
| rdStrobe | output | 1 | Pops `rdByte` at this clock edge |
| wrStrobe | output | 1 | Pushes `wrByte` into the device write FIFO at this clock edge |
| wrByte | output | 8 | Byte of a grant or abort frame |
| payValid | output | 1 | `payByte` holds a payload byte |
| payByte | output | 8 | Payload byte |
| done | output | 1 | One-cycle pulse when reception ends |
| result | output | 3 | Result code, held from `done` until the next one |
| length | output | 16 | Payload length for result 0, else 0 |
| busy | output | 1 | Reception in progress |

## Verification
The poll limit can be reached in the same cycle that the awaited status bit rises, so a timeout and a byte transfer compete for that cycle. The bench holds read-data-present low for a set number of cycles after `start`. With MAX_POLLS-1 low cycles, the byte must be taken and the packet must finish normally. With MAX_POLLS low cycles, the result must be a timeout. A second collision is a time-extension request that arrives exactly when the grant count reaches its limit. That case is judged by the second byte of each written frame.

// File: rtl/reply_rx_pkg.sv
package reply_rx_pkg;
  typedef enum logic [2:0] {
    RES_OK = 3'd0, RES_ABORT_ACK = 3'd1, RES_PROTO = 3'd2, RES_DEV_ERR = 3'd3,
    RES_NAK = 3'd4, RES_VENDOR = 3'd5, RES_TIMEOUT = 3'd6, RES_UNKNOWN = 3'd7
  } result_e;

  localparam int RD_BIT = 7;
  localparam int WR_BIT = 0;
  localparam logic [7:0] VER_BYTE    = 8'h01;
  localparam logic [7:0] CTL_DATA    = 8'h04;
  localparam logic [7:0] CTL_EXT     = 8'h10;
  localparam logic [7:0] CTL_EXT_ABT = 8'h18;
  localparam logic [7:0] CTL_ERROR   = 8'h20;
  localparam logic [7:0] NAK_BYTE    = 8'h15;
  localparam logic [7:0] VENDOR_MARK = 8'h80;
  localparam logic [15:0] VENDOR_LEN = 16'h6D00;
  localparam logic [15:0] INNER_HDR  = 16'd6;

  typedef struct packed {
    logic    rxStart;
    logic    hdrTake;
    logic    bodyTake;
    logic    pollTick;
    logic    grantSel;
    logic    abortSel;
    logic    sendTake;
    logic    pauseTick;
    logic    finish;
    result_e code;
  } dpCmd_t;

  typedef struct packed {
    logic       hdrLast;
    logic       bodyLast;
    logic       lenZero;
    logic       pollLast;
    logic       sendLast;
    logic       pauseLast;
    logic       grantFull;
    logic       verOk;
    logic       vendorHit;
    logic       nakByte;
    logic [7:0] ctl;
  } dpFlag_t;
endpackage

// File: rtl/reply_rx_dp.sv
module reply_rx_dp
  import reply_rx_pkg::*;
#(
  parameter int MAX_POLLS    = 5000,
  parameter int MAX_GRANTS   = 50,
  parameter int PAUSE_CYCLES = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpCmd_t      cmd,
  input  logic [7:0]  rdByte,
  output dpFlag_t     flg,
  output logic [7:0]  wrByte,
  output logic        payValid,
  output logic [7:0]  payByte,
  output logic        done,
  output logic [2:0]  result,
  output logic [15:0] length
);
  localparam int POLL_W  = $clog2(MAX_POLLS + 1);
  localparam int GRANT_W = $clog2(MAX_GRANTS + 1);
  localparam int PAUSE_W = $clog2(PAUSE_CYCLES + 1);

  logic [15:0]        byteIdx, lenReg;
  logic [POLL_W-1:0]  pollCnt;
  logic [GRANT_W-1:0] grantCnt;
  logic [PAUSE_W-1:0] pauseCnt;
  logic [7:0]         ctlReg, body1;
  logic               verReg, frameAbort;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteIdx <= '0; lenReg <= '0; pollCnt <= '0; grantCnt <= '0; pauseCnt <= '0;
      ctlReg <= '0; body1 <= '0; verReg <= 1'b0; frameAbort <= 1'b0;
      payValid <= 1'b0; payByte <= '0; done <= 1'b0; result <= '0; length <= '0;
    end else begin
      payValid <= 1'b0;
      done     <= 1'b0;
      pollCnt  <= cmd.pollTick ? pollCnt + 1'b1 : '0;
      pauseCnt <= cmd.pauseTick ? pauseCnt + 1'b1 : '0;
      if (cmd.rxStart) begin
        byteIdx  <= '0;
        grantCnt <= '0;
      end
      if (cmd.hdrTake) begin
        byteIdx <= flg.hdrLast ? 16'd0 : byteIdx + 16'd1;
        case (byteIdx[1:0])
          2'd0:    verReg <= (rdByte == VER_BYTE);
          2'd1:    ctlReg <= rdByte;
          2'd2:    lenReg[15:8] <= rdByte;
          default: lenReg[7:0] <= rdByte;
        endcase
      end
      if (cmd.bodyTake) begin
        byteIdx <= byteIdx + 16'd1;
        if (byteIdx == 16'd1) body1 <= rdByte;
        if (byteIdx >= INNER_HDR) begin
          payValid <= 1'b1;
          payByte  <= rdByte;
        end
      end
      if (cmd.grantSel) begin
        grantCnt   <= grantCnt + 1'b1;
        frameAbort <= 1'b0;
      end
      if (cmd.abortSel) begin
        grantCnt   <= '0;
        frameAbort <= 1'b1;
      end
      if (cmd.sendTake) byteIdx <= flg.sendLast ? 16'd0 : byteIdx + 16'd1;
      if (cmd.finish) begin
        done   <= 1'b1;
        result <= cmd.code;
        length <= (cmd.code == RES_OK && lenReg > INNER_HDR) ? lenReg - INNER_HDR : 16'd0;
      end
    end
  end

  always_comb begin
    flg.hdrLast   = (byteIdx == 16'd3);
    flg.bodyLast  = (byteIdx == lenReg - 16'd1);
    flg.lenZero   = (lenReg == 16'd0);
    flg.pollLast  = (pollCnt == POLL_W'(MAX_POLLS - 1));
    flg.sendLast  = (byteIdx == 16'd3);
    flg.pauseLast = (pauseCnt == PAUSE_W'(PAUSE_CYCLES - 1));
    flg.grantFull = (grantCnt == GRANT_W'(MAX_GRANTS));
    flg.verOk     = verReg;
    flg.vendorHit = (lenReg == VENDOR_LEN) && (body1 == VENDOR_MARK);
    flg.nakByte   = (rdByte == NAK_BYTE);
    flg.ctl       = ctlReg;
    case (byteIdx[1:0])
      2'd0:    wrByte = VER_BYTE;
      2'd1:    wrByte = frameAbort ? CTL_EXT_ABT : CTL_EXT;
      default: wrByte = 8'h00;
    endcase
  end

  p_poll_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt <= POLL_W'(MAX_POLLS - 1));
  p_grant_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    grantCnt <= GRANT_W'(MAX_GRANTS));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_pay_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    payValid |-> (lenReg > INNER_HDR));
endmodule

// File: rtl/reply_rx_ctl.sv
module reply_rx_ctl
  import reply_rx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    rdReady,
  input  logic    wrReady,
  input  logic    doneIn,
  input  dpFlag_t flg,
  output dpCmd_t  cmd,
  output logic    rdStrobe,
  output logic    wrStrobe,
  output logic    busy
);
  typedef enum logic [2:0] {S_IDLE, S_HDR, S_DISP, S_BODY, S_ERRB, S_SEND, S_PAUSE} state_e;
  state_e st, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= S_IDLE;
    else       st <= nxt;
  end

  assign busy = (st != S_IDLE);

  always_comb begin
    cmd      = '0;
    nxt      = st;
    rdStrobe = 1'b0;
    wrStrobe = 1'b0;
    case (st)
      S_IDLE: if (start) begin
        cmd.rxStart = 1'b1;
        nxt = S_HDR;
      end
      S_HDR, S_BODY, S_ERRB: begin
        if (rdReady) begin
          rdStrobe = 1'b1;
          if (st == S_HDR) begin
            cmd.hdrTake = 1'b1;
            if (flg.hdrLast) nxt = S_DISP;
          end else if (st == S_BODY) begin
            cmd.bodyTake = 1'b1;
            if (flg.bodyLast) begin
              cmd.finish = 1'b1;
              cmd.code   = flg.vendorHit ? RES_VENDOR : RES_OK;
              nxt = S_IDLE;
            end
          end else begin
            cmd.finish = 1'b1;
            cmd.code   = flg.nakByte ? RES_NAK : RES_DEV_ERR;
            nxt = S_IDLE;
          end
        end else if (flg.pollLast) begin
          cmd.finish = 1'b1;
          cmd.code   = RES_TIMEOUT;
          nxt = S_IDLE;
        end else begin
          cmd.pollTick = 1'b1;
        end
      end
      S_DISP: begin
        if (!flg.verOk) begin
          cmd.finish = 1'b1; cmd.code = RES_PROTO; nxt = S_IDLE;
        end else begin
          case (flg.ctl)
            CTL_DATA: if (flg.lenZero) begin
              cmd.finish = 1'b1; cmd.code = RES_OK; nxt = S_IDLE;
            end else nxt = S_BODY;
            CTL_EXT: begin
              if (flg.grantFull) cmd.abortSel = 1'b1;
              else               cmd.grantSel = 1'b1;
              nxt = S_SEND;
            end
            CTL_EXT_ABT: begin
              cmd.finish = 1'b1; cmd.code = RES_ABORT_ACK; nxt = S_IDLE;
            end
            CTL_ERROR: nxt = S_ERRB;
            default: begin
              cmd.finish = 1'b1; cmd.code = RES_UNKNOWN; nxt = S_IDLE;
            end
          endcase
        end
      end
      S_SEND: begin
        if (wrReady) begin
          wrStrobe     = 1'b1;
          cmd.sendTake = 1'b1;
          if (flg.sendLast) nxt = S_PAUSE;
        end else if (flg.pollLast) begin
          cmd.finish = 1'b1; cmd.code = RES_TIMEOUT; nxt = S_IDLE;
        end else begin
          cmd.pollTick = 1'b1;
        end
      end
      S_PAUSE: begin
        cmd.pauseTick = 1'b1;
        if (flg.pauseLast) nxt = S_HDR;
      end
      default: nxt = S_IDLE;
    endcase
  end

  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    doneIn |-> !busy);
  p_busy_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));
endmodule

// File: rtl/reply_rx.sv
module reply_rx
  import reply_rx_pkg::*;
#(
  parameter int MAX_POLLS    = 5000,
  parameter int MAX_GRANTS   = 50,
  parameter int PAUSE_CYCLES = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [7:0]  devStat,
  input  logic [7:0]  rdByte,
  output logic        rdStrobe,
  output logic        wrStrobe,
  output logic [7:0]  wrByte,
  output logic        payValid,
  output logic [7:0]  payByte,
  output logic        done,
  output logic [2:0]  result,
  output logic [15:0] length,
  output logic        busy
);
  dpCmd_t  cmd;
  dpFlag_t flg;

  reply_rx_ctl u_ctl (
    .clk(clk), .rstN(rstN), .start(start),
    .rdReady(devStat[RD_BIT]), .wrReady(devStat[WR_BIT]), .doneIn(done),
    .flg(flg), .cmd(cmd), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .busy(busy)
  );

  reply_rx_dp #(
    .MAX_POLLS(MAX_POLLS), .MAX_GRANTS(MAX_GRANTS), .PAUSE_CYCLES(PAUSE_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .rdByte(rdByte), .flg(flg),
    .wrByte(wrByte), .payValid(payValid), .payByte(payByte),
    .done(done), .result(result), .length(length)
  );
endmodule

// File: tb/sim_reply_rx.sv
module sim_reply_rx;
  localparam int MAXP  = 5000;
  localparam int PAUSE = 20;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0, start = 1'b0, wrReady = 1'b1;
  logic rdStrobe, wrStrobe, payValid, done, busy;
  logic [7:0] wrByte, payByte, rdByte, devStat;
  logic [2:0] result;
  logic [15:0] length;

  int checks = 0, fails = 0;
  logic [7:0] q [0:4095];
  logic [7:0] wlog [0:1023];
  logic [7:0] plog [0:255];
  int rdIdx = 0, qFill = 0, padTotal = 0, padDone = 0, gapReq = 0, pktBase = 0;
  int rxCyc = 0, cyc = 0, wN = 0, pN = 0, lastWrCyc = 0, rdGap = 0;
  bit wrSeen = 1'b0;
  logic [2:0] gotRes;
  logic [15:0] gotLen;

  wire inQ = (rdIdx < qFill);
  wire avail = inQ ? ((rdIdx != pktBase) || (rxCyc >= gapReq)) : (padDone < padTotal);
  assign rdByte  = inQ ? q[rdIdx % 4096] : 8'hA5;
  assign devStat = {avail, 6'b0, wrReady};

  reply_rx #(.MAX_POLLS(MAXP), .MAX_GRANTS(50), .PAUSE_CYCLES(PAUSE)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .devStat(devStat), .rdByte(rdByte),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .wrByte(wrByte),
    .payValid(payValid), .payByte(payByte), .done(done), .result(result),
    .length(length), .busy(busy));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rxCyc <= start ? 0 : rxCyc + 1;
    if (rdStrobe) begin
      if (inQ) rdIdx <= rdIdx + 1; else padDone <= padDone + 1;
      if (wrSeen) begin rdGap <= cyc - lastWrCyc; wrSeen <= 1'b0; end
    end
    if (wrStrobe) begin
      wlog[wN % 1024] <= wrByte; wN <= wN + 1; lastWrCyc <= cyc; wrSeen <= 1'b1;
    end
    if (payValid) begin plog[pN % 256] <= payByte; pN <= pN + 1; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    q[qFill % 4096] = b; qFill++;
  endtask

  task automatic push4(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c, input logic [7:0] d);
    push(a); push(b); push(c); push(d);
  endtask

  task automatic begin_pkt(input int gap);
    pktBase = qFill; gapReq = gap;
  endtask

  task automatic run_rx(input string tag);
    bit seen = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < 40000 && !seen; i++) begin
      if (done) begin seen = 1'b1; gotRes = result; gotLen = length; end
      else @(negedge clk);
    end
    if (!seen) chk(1'b0, {tag, " no done"}, 0, 1);
    @(negedge clk);
    qFill = rdIdx; padTotal = padDone; gapReq = 0;
  endtask

  task automatic t_reset();
    chk(!busy && !done && !payValid && !rdStrobe && !wrStrobe, "R1 reset outputs", busy, 0);
  endtask

  task automatic t_data();
    int p0 = pN;
    begin_pkt(0);
    push4(8'h01, 8'h04, 8'h00, 8'h0A);
    push4(8'h01, 8'h0B, 8'h00, 8'h00); push(8'h00); push(8'h04);
    push4(8'hDE, 8'hAD, 8'hBE, 8'hEF);
    run_rx("R3");
    chk(gotRes == 3'd0, "R3 data result", gotRes, 0);
    chk(gotLen == 16'd4, "R3 data length", gotLen, 4);
    chk(pN - p0 == 4, "R3 payload count", pN - p0, 4);
    chk({plog[p0%256], plog[(p0+1)%256], plog[(p0+2)%256], plog[(p0+3)%256]} == 32'hDEADBEEF,
        "R3 payload order", {plog[p0%256], plog[(p0+1)%256]}, 16'hDEAD);
  endtask

  task automatic t_short_data();
    int p0 = pN;
    begin_pkt(0);
    push4(8'h01, 8'h04, 8'h00, 8'h03); push(8'h11); push(8'h22); push(8'h33);
    run_rx("R3 short");
    chk(gotRes == 3'd0 && gotLen == 16'd0 && pN == p0, "R3 short body", gotLen, 0);
  endtask

  task automatic t_mark_not_vendor();
    begin_pkt(0);
    push4(8'h01, 8'h04, 8'h00, 8'h08);
    push4(8'h00, 8'h80, 8'h00, 8'h00); push4(8'h00, 8'h00, 8'h5A, 8'h5B);
    run_rx("R9 boundary");
    chk(gotRes == 3'd0 && gotLen == 16'd2, "R9 marker with other length", gotRes, 0);
  endtask

  task automatic t_vendor();
    begin_pkt(0);
    push4(8'h01, 8'h04, 8'h6D, 8'h00); push(8'h00); push(8'h80);
    padTotal = padDone + 16'h6D00 - 2;
    run_rx("R9");
    chk(gotRes == 3'd5, "R9 vendor error result", gotRes, 5);
  endtask

  task automatic t_proto();
    int b;
    begin_pkt(0); b = qFill;
    push4(8'h02, 8'h04, 8'h00, 8'h01); push(8'h77); push(8'h78);
    run_rx("R2");
    chk(gotRes == 3'd2, "R2 bad version result", gotRes, 2);
    chk(rdIdx - b == 4, "R2 bytes read", rdIdx - b, 4);
  endtask

  task automatic t_abort_ack();
    begin_pkt(0);
    push4(8'h01, 8'h18, 8'h00, 8'h00);
    run_rx("R7");
    chk(gotRes == 3'd1 && gotLen == 16'd0, "R7 abort ack", gotRes, 1);
  endtask

  task automatic t_error();
    begin_pkt(0);
    push4(8'h01, 8'h20, 8'h00, 8'h01); push(8'h15);
    run_rx("R8 nak");
    chk(gotRes == 3'd4, "R8 nak result", gotRes, 4);
    begin_pkt(0);
    push4(8'h01, 8'h20, 8'h00, 8'h01); push(8'h07);
    run_rx("R8 err");
    chk(gotRes == 3'd3, "R8 device error result", gotRes, 3);
  endtask

  task automatic t_unknown();
    begin_pkt(0);
    push4(8'h01, 8'h55, 8'h00, 8'h00);
    run_rx("R11");
    chk(gotRes == 3'd7, "R11 unknown control", gotRes, 7);
  endtask

  task automatic t_single_grant();
    int w0 = wN, wHold;
    begin_pkt(0);
    push4(8'h01, 8'h10, 8'h00, 8'h00);
    push4(8'h01, 8'h18, 8'h00, 8'h00);
    wrReady = 1'b0;
    fork
      run_rx("R4");
      begin
        repeat (30) @(negedge clk);
        wHold = wN;
        wrReady = 1'b1;
      end
    join
    chk(wHold == w0, "R4 no write while bit0 low", wHold - w0, 0);
    chk(wN - w0 == 4 && {wlog[w0%1024], wlog[(w0+1)%1024], wlog[(w0+2)%1024], wlog[(w0+3)%1024]} == 32'h01100000,
        "R4 grant frame", {wlog[w0%1024], wlog[(w0+1)%1024]}, 16'h0110);
    chk(rdGap == PAUSE + 1, "R4 pause before new header", rdGap, PAUSE + 1);
    chk(gotRes == 3'd1, "R4 result after grant", gotRes, 1);
  endtask

  task automatic t_limit();
    int w0 = wN, bad = 0;
    begin_pkt(0);
    for (int i = 0; i < 52; i++) push4(8'h01, 8'h10, 8'h00, 8'h00);
    push4(8'h01, 8'h18, 8'h00, 8'h00);
    run_rx("R5");
    chk(wN - w0 == 52 * 4, "R5 frame count", (wN - w0) / 4, 52);
    for (int f = 0; f < 52; f++)
      if (wlog[(w0 + 4*f + 1) % 1024] != ((f == 50) ? 8'h18 : 8'h10)) bad++;
    chk(bad == 0, "R5 abort on request 51 then grant", bad, 0);
    chk(wlog[(w0 + 200) % 1024] == 8'h01 && wlog[(w0 + 203) % 1024] == 8'h00,
        "R5 abort frame bytes", wlog[(w0 + 200) % 1024], 1);
  endtask

  task automatic t_restart_clear();
    int w0, bad = 0;
    for (int r = 0; r < 2; r++) begin
      w0 = wN;
      begin_pkt(0);
      for (int i = 0; i < 30; i++) push4(8'h01, 8'h10, 8'h00, 8'h00);
      push4(8'h01, 8'h18, 8'h00, 8'h00);
      run_rx("R6");
    end
    for (int f = 0; f < 30; f++)
      if (wlog[(w0 + 4*f + 1) % 1024] != 8'h10) bad++;
    chk(bad == 0 && gotRes == 3'd1, "R6 grant count cleared on start", bad, 0);
  endtask

  task automatic t_timeout();
    begin_pkt(MAXP - 1);
    push4(8'h01, 8'h18, 8'h00, 8'h00);
    run_rx("R10 edge");
    chk(gotRes == 3'd1, "R10 ready on last poll accepted", gotRes, 1);
    begin_pkt(MAXP);
    push4(8'h01, 8'h18, 8'h00, 8'h00);
    run_rx("R10 expire");
    chk(gotRes == 3'd6, "R10 timeout result", gotRes, 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy, "R1 idle without start", busy, 0);
    t_data();
    t_short_data();
    t_mark_not_vendor();
    t_proto();
    t_abort_ack();
    t_error();
    t_unknown();
    t_single_grant();
    t_limit();
    t_restart_clear();
    t_timeout();
    t_vendor();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule